// File: doc/BRIEF.md
# Raster Timing Generator with Border Regions

This block produces the line and frame timing for a raster display from a free-running pixel clock. Two counters, one per axis, step through a line of pixels and a frame of lines. Each counter position is decoded into sync, back porch, leading border, active picture, trailing border and front porch. Each boundary is given as the count at which its region begins, not as a width. The block drives horizontal and vertical sync, a picture-enable flag, a border flag, and the current pixel and line position.

Software programs the block through a simple write port. Six timing words (three per axis) and one control word are held in the block. The control word starts and stops the generator and sets the sync polarity of each axis. Timing words first land in shadow copies, and the running counters only take them up at a frame boundary. This lets software retime a live display without a torn frame. While the generator is stopped, new timing is taken up at once.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the generator is stopped: x and y are 0, picture and border flags are low, and both sync outputs are high (polarity bits reset to 0, so the inactive level is high).
- R2: Write address 0/1/2 selects horizontal timing words A/B/C, 3/4/5 the vertical words A/B/C, and 6 the control word. Each timing word has a low field in bits 11:0 and a high field in bits 27:16, and all other bits are ignored. Word A holds {high: sync end, low: total}, word B holds {high: picture start, low: leading border start}, and word C holds {high: front porch start, low: trailing border start}.
- R3: The generator runs only when control bit 31 is 1 and bits 0 and 2 are both 0. Any other value stops it. Once stopped, x and y are 0 from the next cycle on, picture and border flags are low, and each sync output sits at its inactive level.
- R4: While running, x advances by one each clock and returns to 0 on the clock after it equals horizontal total minus one.
- R5: y advances by one on each x wrap and returns to 0 on the x wrap that occurs while y equals vertical total minus one. It does not change at any other time while running.
- R6: An axis's sync is active while that axis's count is below its sync-end value. Control bit 1 (horizontal) and bit 3 (vertical) give an active-high pulse when 1 and an active-low pulse when 0.
- R7: The picture flag is high when, on both axes, the count is at or above picture start and below trailing border start.
- R8: The border flag is high when, on both axes, the count is at or above leading border start and below front porch start, and the picture flag is low. The two flags are never high together.
- R9: A timing word written while running takes effect only on the first cycle of the next frame (x and y both 0). A timing word written while stopped is in effect when the generator next runs.
- R10: A write to the control word changes run state and sync polarity on the next cycle, without waiting for a frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 3 |
| border_o | output | 1 | High inside the border frame around the picture |
| display_o | output | 1 | High inside the active picture |
| x_o | output | 12 | Current pixel position in the line |
| y_o | output | 12 | Current line position in the frame |

## Verification
The hardest case to reach is a timing write that lands in the middle of a running frame. The old line length must persist to the frame's end, and the new one must appear on the very first line of the next frame. The stimulus first programs a small raster (20 pixels by 10 lines) so that whole frames take only 200 clocks. It then steps until the position is mid-line on the first line and writes a longer line total. The bench checks that the wrap still occurs at the old total, runs to the next frame origin, and checks that x now reaches the new maximum. A reference model kept in the bench tracks shadow and active timing separately, so every cycle around the boundary is compared.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // width of every timing count
   localparam int unsigned TW         = 12;
   // bit position of the high field in a timing word
   localparam int unsigned HI_LSB     = 16;
   // three timing words per axis, two axes
   localparam int unsigned WORDS_AXIS = 3;
   localparam int unsigned NUM_AXES   = 2;
   localparam int unsigned NUM_TWORDS = WORDS_AXIS * NUM_AXES;
   localparam int unsigned CTRL_ADDR  = NUM_TWORDS;

   // control word bit positions
   localparam int unsigned RUN_BIT   = 31;
   localparam int unsigned HSTOP_BIT = 0;
   localparam int unsigned VSTOP_BIT = 2;
   localparam int unsigned HPOL_BIT  = 1;
   localparam int unsigned VPOL_BIT  = 3;

   // start positions of each region of one axis
   typedef struct packed {
      logic [TW-1:0] total;
      logic [TW-1:0] sync_end;
      logic [TW-1:0] lead_brd;
      logic [TW-1:0] pic;
      logic [TW-1:0] trail_brd;
      logic [TW-1:0] porch;
   } axis_tim_t;

   typedef enum logic [0:0] { AX_H = 1'b0, AX_V = 1'b1 } axis_e;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_end,
   output axis_tim_t         h_act,
   output axis_tim_t         v_act,
   output logic              run,
   output logic              hpol,
   output logic              vpol
);

   logic [TW-1:0] sh_lo [NUM_TWORDS];
   logic [TW-1:0] sh_hi [NUM_TWORDS];

   // one shadow word per address, each field masked to its count width
   for (genvar w = 0; w < NUM_TWORDS; w++) begin : g_word
      logic [TW-1:0] lo_q, hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(w))) begin
            lo_q <= wr_data[TW-1:0];
            hi_q <= wr_data[HI_LSB +: TW];
         end
      end
      assign sh_lo[w] = lo_q;
      assign sh_hi[w] = hi_q;
   end

   // control word: run state is folded to one flop when written
   logic run_q, hpol_q, vpol_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         hpol_q <= 1'b0;
         vpol_q <= 1'b0;
      end else if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) begin
         run_q  <= wr_data[RUN_BIT] & ~wr_data[HSTOP_BIT] & ~wr_data[VSTOP_BIT];
         hpol_q <= wr_data[HPOL_BIT];
         vpol_q <= wr_data[VPOL_BIT];
      end
   end

   // shadow words gathered per axis
   axis_tim_t sh_tim [NUM_AXES];
   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      localparam int unsigned B = a * WORDS_AXIS;
      assign sh_tim[a] = '{total:     sh_lo[B],
                           sync_end:  sh_hi[B],
                           lead_brd:  sh_lo[B+1],
                           pic:       sh_hi[B+1],
                           trail_brd: sh_lo[B+2],
                           porch:     sh_hi[B+2]};
   end

   // active copy follows shadow while stopped, otherwise at frame end only
   logic load;
   assign load = ~run_q | frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_act <= '0;
         v_act <= '0;
      end else if (load) begin
         h_act <= sh_tim[AX_H];
         v_act <= sh_tim[AX_V];
      end
   end

   assign run  = run_q;
   assign hpol = hpol_q;
   assign vpol = vpol_q;

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
   import rtg_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          adv,
   input  axis_tim_t     tim,
   output logic [TW-1:0] pos,
   output logic          last,
   output logic          in_sync,
   output logic          in_pic,
   output logic          in_frame
);

   logic [TW-1:0] pos_q;

   assign last = (pos_q == (tim.total - TW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (!run) begin
         pos_q <= '0;
      end else if (adv) begin
         pos_q <= last ? '0 : pos_q + TW'(1);
      end
   end

   // each boundary is a start position; region membership by compare
   assign in_sync  = (pos_q < tim.sync_end);
   assign in_pic   = (pos_q >= tim.pic)      && (pos_q < tim.trail_brd);
   assign in_frame = (pos_q >= tim.lead_brd) && (pos_q < tim.porch);
   assign pos      = pos_q;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              border_o,
   output logic              display_o,
   output logic [TW-1:0]     x_o,
   output logic [TW-1:0]     y_o
);

   if (DATA_W <= RUN_BIT) begin : g_bad_data_w
      $error("DATA_W must hold the run bit of the control word");
   end
   if ((2 ** ADDR_W) <= CTRL_ADDR) begin : g_bad_addr_w
      $error("ADDR_W too narrow to reach the control word");
   end
   if (HI_LSB < TW) begin : g_bad_fields
      $error("timing word fields overlap");
   end

   axis_tim_t     h_act, v_act;
   logic          run, hpol, vpol;
   logic          frame_end;
   logic [TW-1:0] h_pos, v_pos;
   logic          h_last, v_last;
   logic          h_sync, v_sync, h_pic, v_pic, h_frm, v_frm;

   rtg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .frame_end (frame_end),
      .h_act     (h_act),
      .v_act     (v_act),
      .run       (run),
      .hpol      (hpol),
      .vpol      (vpol)
   );

   rtg_axis u_hax (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .adv      (1'b1),
      .tim      (h_act),
      .pos      (h_pos),
      .last     (h_last),
      .in_sync  (h_sync),
      .in_pic   (h_pic),
      .in_frame (h_frm)
   );

   rtg_axis u_vax (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .adv      (h_last),
      .tim      (v_act),
      .pos      (v_pos),
      .last     (v_last),
      .in_sync  (v_sync),
      .in_pic   (v_pic),
      .in_frame (v_frm)
   );

   assign frame_end = run & h_last & v_last;

   // sync level per axis: active level chosen by the polarity bit
   logic [NUM_AXES-1:0] sync_act, pol, sync_c;
   assign sync_act = {v_sync, h_sync} & {NUM_AXES{run}};
   assign pol      = {vpol, hpol};
   for (genvar a = 0; a < NUM_AXES; a++) begin : g_pol
      assign sync_c[a] = pol[a] ? sync_act[a] : ~sync_act[a];
   end

   logic disp_c, brd_c;
   assign disp_c = run & h_pic & v_pic;
   assign brd_c  = run & h_frm & v_frm & ~disp_c;

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hsync_o   <= 1'b1;
            vsync_o   <= 1'b1;
            border_o  <= 1'b0;
            display_o <= 1'b0;
            x_o       <= '0;
            y_o       <= '0;
         end else begin
            hsync_o   <= sync_c[AX_H];
            vsync_o   <= sync_c[AX_V];
            border_o  <= brd_c;
            display_o <= disp_c;
            x_o       <= h_pos;
            y_o       <= v_pos;
         end
      end
   end else begin : g_out_comb
      assign hsync_o   = sync_c[AX_H];
      assign vsync_o   = sync_c[AX_V];
      assign border_o  = brd_c;
      assign display_o = disp_c;
      assign x_o       = h_pos;
      assign y_o       = v_pos;
   end

endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
   import rtg_pkg::*;
(
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          hpol,
   input logic          vpol,
   input logic          frame_end,
   input logic          h_last,
   input logic [TW-1:0] h_pos,
   input logic [TW-1:0] v_pos,
   input axis_tim_t     h_act,
   input axis_tim_t     v_act,
   input logic [1:0]    sync_c,
   input logic          disp_c,
   input logic          brd_c
);

   assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (h_pos == '0) && (v_pos == '0));

   assert_idle_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !disp_c && !brd_c && (sync_c[0] == !hpol) && (sync_c[1] == !vpol));

   assert_x_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> !run || (h_pos == '0) || (h_pos == $past(h_pos) + TW'(1)));

   assert_y_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !h_last) |=> !run || $stable(v_pos));

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(disp_c && brd_c));

   assert_timing_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> $stable(h_act) && $stable(v_act));

endmodule

bind raster_timing_gen rtg_chk u_rtg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .hpol      (hpol),
   .vpol      (vpol),
   .frame_end (frame_end),
   .h_last    (h_last),
   .h_pos     (h_pos),
   .v_pos     (v_pos),
   .h_act     (h_act),
   .v_act     (v_act),
   .sync_c    (sync_c),
   .disp_c    (disp_c),
   .brd_c     (brd_c)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync_o, vsync_o, border_o, display_o;
   logic [11:0] x_o, y_o;

   int n_vec = 0;
   int n_bad = 0;

   // reference model state
   int m_lo [6];
   int m_hi [6];
   int a_lo [6];
   int a_hi [6];
   bit m_run = 0, m_hp = 0, m_vp = 0;
   int mx = 0, my = 0;

   always #(CLK_P/2) clk = ~clk;

   raster_timing_gen i_raster_timing_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .hsync_o   (hsync_o),
      .vsync_o   (vsync_o),
      .border_o  (border_o),
      .display_o (display_o),
      .x_o       (x_o),
      .y_o       (y_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // model one clock edge from the requirements
   task automatic model_edge(input bit we, input int addr, input logic [31:0] d);
      bit run0, hl, vl;
      run0 = m_run;
      hl   = run0 && (mx == a_lo[0] - 1);
      vl   = (my == a_lo[3] - 1);
      if (!run0) begin
         mx = 0; my = 0;
      end else if (hl) begin
         mx = 0;
         my = vl ? 0 : my + 1;
      end else begin
         mx = mx + 1;
      end
      if (!run0 || (hl && vl)) begin
         for (int i = 0; i < 6; i++) begin
            a_lo[i] = m_lo[i];
            a_hi[i] = m_hi[i];
         end
      end
      if (we) begin
         if (addr < 6) begin
            m_lo[addr] = int'(d[11:0]);
            m_hi[addr] = int'(d[27:16]);
         end else if (addr == 6) begin
            m_run = d[31] && !d[0] && !d[2];
            m_hp  = d[1];
            m_vp  = d[3];
         end
      end
   endtask

   task automatic compare_all();
      bit hs, vs, hd, vd, hb, vb, ed, eb;
      string t;
      hs = m_run && (mx < a_hi[0]);
      vs = m_run && (my < a_hi[3]);
      hd = (mx >= a_hi[1]) && (mx < a_lo[2]);
      vd = (my >= a_hi[4]) && (my < a_lo[5]);
      hb = (mx >= a_lo[1]) && (mx < a_hi[2]);
      vb = (my >= a_lo[4]) && (my < a_hi[5]);
      ed = m_run && hd && vd;
      eb = m_run && hb && vb && !ed;
      t = m_run ? "" : " R3";
      chk({"R4 x", t}, int'(x_o), mx);
      chk({"R5 y", t}, int'(y_o), my);
      chk({"R6 hsync", t}, int'(hsync_o), int'(m_hp ? hs : !hs));
      chk({"R6 vsync", t}, int'(vsync_o), int'(m_vp ? vs : !vs));
      chk({"R7 display", t}, int'(display_o), int'(ed));
      chk({"R8 border", t}, int'(border_o), int'(eb));
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input bit we, input int addr, input logic [31:0] d);
      wr_en   = we;
      wr_addr = addr[2:0];
      wr_data = d;
      @(posedge clk);
      model_edge(we, addr, d);
      @(negedge clk);
      wr_en = 1'b0;
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, '0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 x", int'(x_o), 0);
      chk("R1 y", int'(y_o), 0);
      chk("R1 hsync", int'(hsync_o), 1);
      chk("R1 vsync", int'(vsync_o), 1);
      chk("R1 display", int'(display_o), 0);
      chk("R1 border", int'(border_o), 0);
   endtask

   task automatic t_program_run();
      // junk in ignored bits 31:28 and 15:12 (R2)
      step(1'b1, 0, 32'hF002_F014);
      step(1'b1, 1, 32'h0006_0004);
      step(1'b1, 2, 32'h0010_000E);
      step(1'b1, 3, 32'hA001_500A);
      step(1'b1, 4, 32'h0003_0002);
      step(1'b1, 5, 32'h0008_0007);
      step(1'b1, 6, 32'h8000_0000);
      idle(19);
      chk("R2 line max", int'(x_o), 19);
      step(1'b0, 0, '0);
      chk("R2 line wrap", int'(x_o), 0);
      idle(420);
   endtask

   task automatic t_polarity();
      step(1'b1, 6, 32'h8000_000A);
      chk("R10 hsync level", int'(hsync_o), int'(mx < 2));
      idle(250);
   endtask

   task automatic t_shadow();
      for (int i = 0; i < 400 && !(mx == 5 && my == 0); i++) step(1'b0, 0, '0);
      step(1'b1, 0, 32'h0002_0018);
      idle(13);
      chk("R9 old total kept", int'(x_o), 19);
      step(1'b0, 0, '0);
      chk("R9 old total wrap", int'(x_o), 0);
      for (int i = 0; i < 400 && !(mx == 0 && my == 0); i++) step(1'b0, 0, '0);
      idle(23);
      chk("R9 new total", int'(x_o), 23);
      idle(260);
   endtask

   task automatic t_stop();
      step(1'b1, 6, 32'h0000_0005);
      idle(5);
      chk("R3 stopped x", int'(x_o), 0);
      step(1'b1, 6, 32'h8000_0001);
      idle(5);
      chk("R3 bit0 stops", int'(x_o), 0);
      chk("R3 bit0 hsync idle", int'(hsync_o), 1);
      step(1'b1, 6, 32'h8000_0004);
      idle(3);
      chk("R3 bit2 stops", int'(display_o), 0);
      step(1'b1, 0, 32'h0002_0014);
      step(1'b1, 6, 32'h8000_0000);
      idle(19);
      chk("R9 stopped write", int'(x_o), 19);
      step(1'b0, 0, '0);
      chk("R9 stopped wrap", int'(x_o), 0);
      idle(210);
   endtask

   initial begin
      for (int i = 0; i < 6; i++) begin
         m_lo[i] = 0; m_hi[i] = 0; a_lo[i] = 0; a_hi[i] = 0;
      end
      repeat (3) @(posedge clk);
      t_reset();
      rst_n = 1'b1;
      t_program_run();
      t_polarity();
      t_shadow();
      t_stop();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule